// File: doc/BRIEF.md
# Hashed Page Table Lookup Key Generator

This block turns one address translation request into the values a hashed page table walker needs before it touches memory. Each request gives a 64-bit effective address, a virtual segment identifier, a segment-size code and the base-two logarithm of the page size. From these the block forms the virtual page number, held with its low 12 bits dropped. It then derives the primary hash, the primary and secondary group indices under a caller-supplied table mask, and the word that is compared against the first doubleword of each page table entry.

A group holds eight entries of 16 bytes, so a group index times 128 gives a byte offset into the table. Entries are compared on every bit except the low seven. The block only prepares keys. Reading the table, comparing entries and updating the table are left to the surrounding logic. Every output is registered, so results appear one cycle after the request, together with a valid flag and two error flags.

Top module: `hpt_key_gen`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `req_valid` high, and low in the cycle after a cycle with `req_valid` low. Synchronous reset clears `out_valid` and every data and flag output to zero.
- R2: With segment code 0 (256 MB), the segment bit count S is 16. With segment code 1 (1 TB), S is 28. `out_vpn` = (vsid << S) | ((ea >> 12) & (2^S − 1)), truncated to 64 bits.
- R3: For segment code 0, `out_hash` = the low 39 bits of (vpn >> 16) XOR ((vpn & 0xFFFF) >> (pshift − 12)).
- R4: For segment code 1, with g = vpn >> 28, `out_hash` = the low 39 bits of g XOR (g << 25) XOR ((vpn & 0xFFFFFFF) >> (pshift − 12)).
- R5: `out_pgrp` = hash AND `tbl_mask`. `out_sgrp` = (NOT hash) AND `tbl_mask`. Both use the mask presented with the request.
- R6: `out_match` = (((vpn >> 11) with its low (pshift − 23) bits cleared when pshift > 23) << 7), truncated to 64 bits. The 2-bit segment code sits at bits 63:62, and bits 6:3 and 1:0 are zero.
- R7: Bit 2 of `out_match` (large page) is 1 exactly when pshift is not 12.
- R8: A segment code of 2 or 3 is reserved. It sets `out_seg_err`, clears `out_psz_err`, and forces vpn, hash, both group indices and the match word to zero.
- R9: With a legal segment code, a pshift below 12 or above the segment shift (28 for code 0, 40 for code 1) sets `out_psz_err` and forces all data outputs to zero.
- R10: While `req_valid` is low, the data and error outputs keep the values of the last accepted request, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_ea | input | 64 | Effective address |
| req_vsid | input | 36 | Virtual segment identifier |
| req_seg | input | 2 | Segment size code: 0 = 256 MB, 1 = 1 TB, 2 and 3 reserved |
| req_pshift | input | 6 | Page size as log2 of bytes |
| tbl_mask | input | 39 | Group index mask of the table |
| out_valid | output | 1 | Registered result valid |
| out_vpn | output | 64 | Virtual page number (address >> 12) |
| out_hash | output | 39 | Primary hash |
| out_pgrp | output | 39 | Primary group index |
| out_sgrp | output | 39 | Secondary group index |
| out_match | output | 64 | First-doubleword compare word |
| out_seg_err | output | 1 | Reserved segment code seen |
| out_psz_err | output | 1 | Page shift out of range |

## Verification
The bench builds the block with its default widths: a 64-bit address, a 36-bit segment identifier and a 39-bit hash. With these widths the 64-bit arithmetic in the bench reproduces every field exactly. The bench sweeps all four segment codes against every page shift from 0 to 45. It uses three address and identifier patterns, with both a full mask and a narrow mask. This covers both hash variants, both edges of the legal page-shift window, the point where the compare mask starts clearing bits above a shift of 23, and both reserved codes. Between requests it changes the inputs while `req_valid` is low to confirm that the outputs hold.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int PG_BASE_SHIFT  = 12;
  localparam int SEG_SHIFT_SMALL = 28;
  localparam int SEG_SHIFT_BIG   = 40;
  localparam int CMP_DROP_BITS   = 23;
  localparam int CMP_LOW_BITS    = 7;

  typedef enum logic [1:0] {
    SEG_256M = 2'd0,
    SEG_1T   = 2'd1,
    SEG_RSV2 = 2'd2,
    SEG_RSV3 = 2'd3
  } seg_code_e;
endpackage

// File: rtl/hpt_vpn_form.sv
module hpt_vpn_form #(
  parameter int VPN_W  = 64,
  parameter int VSID_W = 36
) (
  input  logic [VPN_W-1:0]  ea,
  input  logic [VSID_W-1:0] vsid,
  input  logic              is_big,
  output logic [VPN_W-1:0]  vpn
);
  import hpt_pkg::*;
  localparam int SB_SMALL = SEG_SHIFT_SMALL - PG_BASE_SHIFT;
  localparam int SB_BIG   = SEG_SHIFT_BIG - PG_BASE_SHIFT;

  logic [5:0]       sbits;
  logic [VPN_W-1:0] low_mask;
  logic [VPN_W-1:0] vsid_ext;

  always_comb begin
    sbits    = is_big ? 6'(SB_BIG) : 6'(SB_SMALL);
    low_mask = (VPN_W'(1) << sbits) - VPN_W'(1);
    vsid_ext = VPN_W'(vsid);
    vpn      = (vsid_ext << sbits) | ((ea >> PG_BASE_SHIFT) & low_mask);
  end
endmodule

// File: rtl/hpt_hash_calc.sv
module hpt_hash_calc #(
  parameter int VPN_W  = 64,
  parameter int HASH_W = 39
) (
  input  logic [VPN_W-1:0]  vpn,
  input  logic              is_big,
  input  logic [5:0]        rel_shift,
  output logic [HASH_W-1:0] hash
);
  import hpt_pkg::*;
  localparam int SB_SMALL = SEG_SHIFT_SMALL - PG_BASE_SHIFT;
  localparam int SB_BIG   = SEG_SHIFT_BIG - PG_BASE_SHIFT;
  localparam int FOLD     = 25;

  logic [VPN_W-1:0] seg_part;
  logic [VPN_W-1:0] page_part;
  logic [VPN_W-1:0] full;

  always_comb begin
    if (is_big) begin
      seg_part  = vpn >> SB_BIG;
      page_part = (vpn & ((VPN_W'(1) << SB_BIG) - VPN_W'(1))) >> rel_shift;
      full      = seg_part ^ (seg_part << FOLD) ^ page_part;
    end else begin
      seg_part  = vpn >> SB_SMALL;
      page_part = (vpn & ((VPN_W'(1) << SB_SMALL) - VPN_W'(1))) >> rel_shift;
      full      = seg_part ^ page_part;
    end
    hash = full[HASH_W-1:0];
  end
endmodule

// File: rtl/hpt_match_enc.sv
module hpt_match_enc #(
  parameter int VPN_W = 64
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [1:0]       seg,
  input  logic [5:0]       pshift,
  output logic [VPN_W-1:0] match
);
  import hpt_pkg::*;
  localparam int AVA_SHIFT = CMP_DROP_BITS - PG_BASE_SHIFT;
  localparam int SEG_POS   = VPN_W - 2;
  localparam int LARGE_POS = 2;

  logic [VPN_W-1:0] clr_mask;
  logic [VPN_W-1:0] ava;

  for (genvar i = 0; i < VPN_W; i++) begin : g_clr
    assign clr_mask[i] = int'(pshift) > (CMP_DROP_BITS + i);
  end

  always_comb begin
    ava   = (vpn >> AVA_SHIFT) & ~clr_mask;
    match = ava << CMP_LOW_BITS;
    match[SEG_POS +: 2] = seg;
    match[LARGE_POS]    = (int'(pshift) != PG_BASE_SHIFT);
  end
endmodule

// File: rtl/hpt_key_gen.sv
module hpt_key_gen #(
  parameter int EA_W   = 64,
  parameter int VSID_W = 36,
  parameter int HASH_W = 39
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [EA_W-1:0]   req_ea,
  input  logic [VSID_W-1:0] req_vsid,
  input  logic [1:0]        req_seg,
  input  logic [5:0]        req_pshift,
  input  logic [HASH_W-1:0] tbl_mask,
  output logic              out_valid,
  output logic [EA_W-1:0]   out_vpn,
  output logic [HASH_W-1:0] out_hash,
  output logic [HASH_W-1:0] out_pgrp,
  output logic [HASH_W-1:0] out_sgrp,
  output logic [EA_W-1:0]   out_match,
  output logic              out_seg_err,
  output logic              out_psz_err
);
  import hpt_pkg::*;
  localparam int VPN_W = EA_W;

  logic              is_big;
  logic              seg_bad;
  logic              psz_bad;
  logic              any_bad;
  logic [5:0]        rel_shift;
  logic [VPN_W-1:0]  vpn_c;
  logic [HASH_W-1:0] hash_c;
  logic [VPN_W-1:0]  match_c;

  always_comb begin
    is_big    = (seg_code_e'(req_seg) == SEG_1T);
    seg_bad   = req_seg[1];
    psz_bad   = !seg_bad &&
                ((int'(req_pshift) < PG_BASE_SHIFT) ||
                 (int'(req_pshift) > (is_big ? SEG_SHIFT_BIG : SEG_SHIFT_SMALL)));
    any_bad   = seg_bad || psz_bad;
    rel_shift = req_pshift - 6'(PG_BASE_SHIFT);
  end

  hpt_vpn_form #(.VPN_W(VPN_W), .VSID_W(VSID_W)) u_vpn (
    .ea(req_ea), .vsid(req_vsid), .is_big(is_big), .vpn(vpn_c)
  );

  hpt_hash_calc #(.VPN_W(VPN_W), .HASH_W(HASH_W)) u_hash (
    .vpn(vpn_c), .is_big(is_big), .rel_shift(rel_shift), .hash(hash_c)
  );

  hpt_match_enc #(.VPN_W(VPN_W)) u_match (
    .vpn(vpn_c), .seg(req_seg), .pshift(req_pshift), .match(match_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_vpn     <= '0;
      out_hash    <= '0;
      out_pgrp    <= '0;
      out_sgrp    <= '0;
      out_match   <= '0;
      out_seg_err <= 1'b0;
      out_psz_err <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_seg_err <= seg_bad;
        out_psz_err <= psz_bad;
        if (any_bad) begin
          out_vpn   <= '0;
          out_hash  <= '0;
          out_pgrp  <= '0;
          out_sgrp  <= '0;
          out_match <= '0;
        end else begin
          out_vpn   <= vpn_c;
          out_hash  <= hash_c;
          out_pgrp  <= hash_c & tbl_mask;
          out_sgrp  <= ~hash_c & tbl_mask;
          out_match <= match_c;
        end
      end
    end
  end
endmodule

// File: rtl/hpt_key_gen_chk.sv
module hpt_key_gen_chk #(
  parameter int EA_W   = 64,
  parameter int HASH_W = 39
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [5:0]        req_pshift,
  input logic [HASH_W-1:0] tbl_mask,
  input logic              out_valid,
  input logic [HASH_W-1:0] out_hash,
  input logic [HASH_W-1:0] out_pgrp,
  input logic [HASH_W-1:0] out_sgrp,
  input logic [EA_W-1:0]   out_match,
  input logic              out_seg_err,
  input logic              out_psz_err
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid); // R1
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid); // R1
  AST_GROUPS_MASKED: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (((out_pgrp | out_sgrp) & ~$past(tbl_mask)) == '0)
                  && ((out_pgrp & out_sgrp) == '0)); // R5
  AST_MATCH_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_match[6:3] == 4'd0) && (out_match[1:0] == 2'd0)); // R6
  AST_LARGE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_pshift == 6'd12) |=> !out_match[2]); // R7
  AST_SEG_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_seg_err |-> (out_hash == '0) && (out_match == '0) && !out_psz_err); // R8
  AST_PSZ_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_psz_err |-> (out_hash == '0) && (out_pgrp == '0) && (out_match == '0)); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(out_hash) && $stable(out_match) && $stable(out_seg_err)); // R10
endmodule

bind hpt_key_gen hpt_key_gen_chk #(.EA_W(EA_W), .HASH_W(HASH_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_pshift(req_pshift),
  .tbl_mask(tbl_mask), .out_valid(out_valid), .out_hash(out_hash),
  .out_pgrp(out_pgrp), .out_sgrp(out_sgrp), .out_match(out_match),
  .out_seg_err(out_seg_err), .out_psz_err(out_psz_err)
);

// File: tb/sim_hpt_key_gen.sv
module sim_hpt_key_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] req_ea = '0;
  logic [35:0] req_vsid = '0;
  logic [1:0]  req_seg = '0;
  logic [5:0]  req_pshift = '0;
  logic [38:0] tbl_mask = '0;
  logic        out_valid;
  logic [63:0] out_vpn;
  logic [38:0] out_hash, out_pgrp, out_sgrp;
  logic [63:0] out_match;
  logic        out_seg_err, out_psz_err;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  hpt_key_gen u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ea(req_ea),
    .req_vsid(req_vsid), .req_seg(req_seg), .req_pshift(req_pshift),
    .tbl_mask(tbl_mask), .out_valid(out_valid), .out_vpn(out_vpn),
    .out_hash(out_hash), .out_pgrp(out_pgrp), .out_sgrp(out_sgrp),
    .out_match(out_match), .out_seg_err(out_seg_err), .out_psz_err(out_psz_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [63:0] ea, input logic [35:0] vsid,
                         input logic [1:0] seg, input int ps, input logic [38:0] msk);
    logic [63:0] vpn, g, full, ava, clr, m;
    logic [38:0] h;
    int sb;
    bit serr, perr;
    serr = seg[1];
    perr = !serr && (ps < 12 || ps > (seg == 2'd1 ? 40 : 28));
    sb   = (seg == 2'd1) ? 28 : 16;
    vpn  = ({28'd0, vsid} << sb) | ((ea >> 12) & ((64'd1 << sb) - 64'd1));
    if (seg == 2'd1) begin
      g    = vpn >> 28;
      full = g ^ (g << 25) ^ ((vpn & 64'h0FFF_FFFF) >> (ps - 12));
    end else begin
      g    = vpn >> 16;
      full = g ^ ((vpn & 64'hFFFF) >> (ps - 12));
    end
    h   = full[38:0];
    clr = (ps > 23) ? ((64'd1 << (ps - 23)) - 64'd1) : 64'd0;
    ava = (vpn >> 11) & ~clr;
    m   = (ava << 7) | ({62'd0, seg} << 62);
    if (serr || perr) begin
      vpn = '0; h = '0; m = '0;
    end
    @(negedge clk);
    req_ea = ea; req_vsid = vsid; req_seg = seg; req_pshift = 6'(ps);
    tbl_mask = msk; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(out_valid == 1'b1, "R1 valid", 64'(out_valid), 64'd1);
    chk(out_seg_err == serr, "R8 seg_err", 64'(out_seg_err), 64'(serr));
    chk(out_psz_err == perr, "R9 psz_err", 64'(out_psz_err), 64'(perr));
    chk(out_vpn == vpn, (serr || perr) ? "R8/R9 vpn zero" : "R2 vpn", out_vpn, vpn);
    chk(out_hash == h, (seg == 2'd1) ? "R4 hash 1T" : "R3 hash 256M", 64'(out_hash), 64'(h));
    chk(out_pgrp == ((serr || perr) ? 39'd0 : (h & msk)), "R5 pgrp", 64'(out_pgrp), 64'(h & msk));
    chk(out_sgrp == ((serr || perr) ? 39'd0 : (~h & msk)), "R5 sgrp", 64'(out_sgrp), 64'(~h & msk));
    chk((out_match & ~64'd4) == m, "R6 match", out_match & ~64'd4, m);
    chk(out_match[2] == (!(serr || perr) && ps != 12), "R7 large",
        64'(out_match[2]), 64'(!(serr || perr) && ps != 12));
    req_ea = ~ea; req_vsid = ~vsid; req_seg = ~seg; req_pshift = 6'(ps + 7); tbl_mask = ~msk;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 idle", 64'(out_valid), 64'd0);
    chk(out_hash == h && out_match[63:3] == m[63:3] && out_seg_err == serr,
        "R10 hold", 64'(out_hash), 64'(h));
  endtask

  initial begin
    logic [63:0] eas [3];
    logic [35:0] vsids [3];
    eas[0] = 64'h0123_4567_89AB_CDEF; vsids[0] = 36'hA_5A5A_5A5A;
    eas[1] = 64'hFFFF_FFFF_FFFF_FFFF; vsids[1] = 36'hF_FFFF_FFFF;
    eas[2] = 64'hC000_0012_3456_7000; vsids[2] = 36'h0_0000_0001;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_hash == '0 && out_match == '0 && out_vpn == '0,
        "R1 reset state", 64'(out_valid), 64'd0);
    rst = 1'b0;
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 46; p++)
        for (int k = 0; k < 3; k++)
          run_one(eas[k], vsids[k], 2'(s), p, (k == 1) ? 39'h3FF : 39'h7F_FFFF_FFFF);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule